// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a single-channel asynchronous serial transmitter and receiver. A byte-wide register port gives access to five registers: a mode register, a receive data register, an error status register, a transmit data register and a transmit status register. The mode register selects the frame format: 7 or 8 data bits, 1 or 2 stop bits, and one of four parity schemes (none, forced zero, odd, even). An external baud-rate generator supplies `bit_tick`, a one-cycle pulse at sixteen times the bit rate.

Software writes a byte to the transmit data register. The byte waits there until the shifter is free, and then goes out on `txd` as a start bit, the data LSB first, an optional parity bit and the stop bits. The receiver watches `rxd`, samples each bit at mid-bit, and posts a completed character with its parity, framing and overrun status. The block gives three one-cycle interrupt pulses: transmit complete, receive, and a separate receive-error pulse that a mode bit can fold into the receive pulse.

After software clears a transmit or receive enable, both engines stay in reset for a short guard interval before they can run again.

Top module: `async_serial_xcvr`

## Requirements
- R1: The mode register is at address 0 and reads back as written. Bit 7 gates the bit tick. Bit 6 enables transmit and bit 5 enables receive. With all bits zero, `txd` idles high, writes to transmit data are ignored and no character is received. Reset clears every register.
- R2: Mode bit 2 set selects 8 data bits and clear selects 7. In 7-bit mode, 7 bits are sent and bit 7 of the received data reads as zero.
- R3: Mode bits [4:3] select parity: 00 none, 01 a parity bit that is always 0, 10 odd (total of ones in data plus parity is odd), 11 even. The parity bit follows the last data bit.
- R4: Mode bit 1 set sends two stop bits (high); clear sends one.
- R5: A frame is a low start bit, then the data LSB first, then parity, then stop. Each bit lasts 16 enabled ticks. The receiver samples at mid-bit.
- R6: The transmit status register is at address 4. Bit 1 is set while a byte waits in transmit data (address 3). Bit 0 is set while the shifter sends. `tx_irq` pulses for one cycle when the last stop bit ends.
- R7: A received character is read at address 1, and `rx_irq` pulses once per completed character that carries no error. Reading address 1 marks the data consumed.
- R8: The error status register is at address 2: bit 2 parity error, bit 1 framing error (first stop bit sampled low), bit 0 overrun. Each bit stays set until address 2 is read.
- R9: If a character completes before the previous one was read from address 1, the overrun bit is set and the new character replaces the old one.
- R10: Mode bit 0 set makes a character with any error pulse `rx_irq`. Clear makes it pulse `rxerr_irq` instead, and `rx_irq` stays low.
- R11: A mode write that clears the transmit or receive enable holds both engines in reset for 2 enabled ticks. During that time `txd` stays high and writes to transmit data are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | Oversampling tick, 16 per bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears read-sensitive state) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| tx_irq | output | 1 | Transmit-complete pulse |
| rx_irq | output | 1 | Receive pulse |
| rxerr_irq | output | 1 | Receive-error pulse |

## Verification
The transmitter has a bit counter, a tick counter and a state register. If any of them is wrong, the frame on `txd` is one bit too long or too short, or carries a wrong level. A bench that samples each bit at mid-bit sees this within a single frame of about 640 clock cycles. If the receiver's alignment or parity state is wrong, the bad data or a spurious error bit shows at the register port on the first read after the character. Sticky and overrun bookkeeping shows up only when two events run back to back, so those cases are driven on purpose.

// File: rtl/sxcvr_pkg.sv
package sxcvr_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  // Field order matches the mode register bit positions, 7 down to 0.
  typedef struct packed {
    logic      clk_en;
    logic      tx_en;
    logic      rx_en;
    par_mode_e par;
    logic      len8;
    logic      stop2;
    logic      err_on_rx;
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT
  } frame_st_e;

  // d holds the data bits already masked to the active length.
  function automatic logic parity_bit(par_mode_e m, logic [7:0] d);
    case (m)
      PAR_ODD:  parity_bit = ~^d;
      PAR_EVEN: parity_bit = ^d;
      default:  parity_bit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sxcvr_tx.sv
module sxcvr_tx
  import sxcvr_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      tick,
  input  logic      fmt_len8,
  input  logic      fmt_stop2,
  input  par_mode_e fmt_par,
  input  logic      load,
  input  logic [7:0] load_data,
  output logic      txd,
  output logic      buf_full,
  output logic      shift_busy,
  output logic      done
);

  localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  frame_st_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       shreg_q, shreg_d;
  logic [7:0]       hold_q, hold_d;
  logic             full_q, full_d;
  logic             par_q, par_d;
  logic             txd_q, txd_d;
  logic             done_q, done_d;
  logic [2:0]       last_bit;
  logic [7:0]       hold_masked;

  assign last_bit    = fmt_len8 ? 3'd7 : 3'd6;
  assign hold_masked = fmt_len8 ? hold_q : {1'b0, hold_q[6:0]};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    shreg_d = shreg_q;
    hold_d  = hold_q;
    full_d  = full_q;
    par_d   = par_q;
    txd_d   = txd_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        txd_d = 1'b1;
        if (full_q) begin
          state_d = ST_START;
          cnt_d   = '0;
          shreg_d = hold_q;
          par_d   = parity_bit(fmt_par, hold_masked);
          full_d  = 1'b0;
          txd_d   = 1'b0;
        end
      end
      default: begin
        if (tick) begin
          if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
          end else begin
            cnt_d = '0;
            case (state_q)
              ST_START: begin
                state_d = ST_DATA;
                bit_d   = '0;
                txd_d   = shreg_q[0];
              end
              ST_DATA: begin
                if (bit_q == last_bit) begin
                  bit_d = '0;
                  if (fmt_par != PAR_NONE) begin
                    state_d = ST_PAR;
                    txd_d   = par_q;
                  end else begin
                    state_d = ST_STOP;
                    txd_d   = 1'b1;
                  end
                end else begin
                  bit_d   = bit_q + 1'b1;
                  shreg_d = shreg_q >> 1;
                  txd_d   = shreg_q[1];
                end
              end
              ST_PAR: begin
                state_d = ST_STOP;
                bit_d   = '0;
                txd_d   = 1'b1;
              end
              default: begin
                if (fmt_stop2 && (bit_q == 3'd0)) begin
                  bit_d = 3'd1;
                end else begin
                  state_d = ST_IDLE;
                  done_d  = 1'b1;
                end
              end
            endcase
          end
        end
      end
    endcase
    if (load) begin
      hold_d = load_data;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      hold_q  <= '0;
      full_q  <= 1'b0;
      par_q   <= 1'b0;
      txd_q   <= 1'b1;
      done_q  <= 1'b0;
    end else if (!run) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      full_q  <= 1'b0;
      txd_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      hold_q  <= hold_d;
      full_q  <= full_d;
      par_q   <= par_d;
      txd_q   <= txd_d;
      done_q  <= done_d;
    end
  end

  assign txd        = txd_q;
  assign buf_full   = full_q;
  assign shift_busy = (state_q != ST_IDLE);
  assign done       = done_q;

  AST_TX_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (txd && !shift_busy && !buf_full)); // R11
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_busy) |-> !txd); // R5
  AST_TX_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (txd && $past(shift_busy))); // R6

endmodule

// File: rtl/sxcvr_rx.sv
module sxcvr_rx
  import sxcvr_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       fmt_len8,
  input  par_mode_e  fmt_par,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data,
  output logic       perr,
  output logic       ferr
);

  localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);

  logic             rx_meta_q, rx_s_q;
  frame_st_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       shreg_q, shreg_d;
  logic             par_q, par_d;
  logic [7:0]       data_q, data_d;
  logic             perr_q, perr_d;
  logic             ferr_q, ferr_d;
  logic             done_q, done_d;
  logic [2:0]       last_bit;
  logic [7:0]       word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta_q <= 1'b1;
      rx_s_q    <= 1'b1;
    end else begin
      rx_meta_q <= rxd;
      rx_s_q    <= rx_meta_q;
    end
  end

  assign last_bit = fmt_len8 ? 3'd7 : 3'd6;
  assign word     = fmt_len8 ? shreg_q : {1'b0, shreg_q[7:1]};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    shreg_d = shreg_q;
    par_d   = par_q;
    data_d  = data_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tick && !rx_s_q) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
      end
      ST_START: begin
        if (tick) begin
          if (cnt_q == MID) begin
            cnt_d   = '0;
            bit_d   = '0;
            state_d = rx_s_q ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (rx_s_q) state_d = ST_IDLE;
      end
      default: begin
        if (tick) begin
          if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
          end else begin
            cnt_d = '0;
            case (state_q)
              ST_DATA: begin
                shreg_d = {rx_s_q, shreg_q[7:1]};
                if (bit_q == last_bit)
                  state_d = (fmt_par != PAR_NONE) ? ST_PAR : ST_STOP;
                else
                  bit_d = bit_q + 1'b1;
              end
              ST_PAR: begin
                par_d   = rx_s_q;
                state_d = ST_STOP;
              end
              default: begin
                done_d  = 1'b1;
                data_d  = word;
                perr_d  = (fmt_par != PAR_NONE) && (par_q != parity_bit(fmt_par, word));
                ferr_d  = !rx_s_q;
                state_d = ST_WAIT;
              end
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (!run) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      par_q   <= par_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;
  assign data = data_q;
  assign perr = perr_q;
  assign ferr = ferr_q;

  AST_RX_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done); // R11
  AST_RX_SHORT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(fmt_len8)) |-> !data[7]); // R2

endmodule

// File: rtl/async_serial_xcvr.sv
module async_serial_xcvr
  import sxcvr_pkg::*;
#(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned GUARD_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       tx_irq,
  output logic       rx_irq,
  output logic       rxerr_irq
);

  localparam int unsigned GUARD_W = $clog2(GUARD_TICKS + 1);
  localparam logic [2:0] ADR_MODE   = 3'd0;
  localparam logic [2:0] ADR_RXDATA = 3'd1;
  localparam logic [2:0] ADR_ERR    = 3'd2;
  localparam logic [2:0] ADR_TXDATA = 3'd3;
  localparam logic [2:0] ADR_TXSTAT = 3'd4;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  mode_t              mode_q, mode_d, mode_new;
  logic [GUARD_W-1:0] guard_q, guard_d;
  logic [7:0]         rdr_q, rdr_d;
  logic               rfull_q, rfull_d;
  logic [2:0]         err_q, err_d;
  logic               tick_g, tx_run, rx_run;
  logic               wr_mode, rd_rx, rd_err, tx_load, ovr, any_err;
  logic               tx_full, tx_busy, tx_done;
  logic               rx_done, rx_perr, rx_ferr;
  logic [7:0]         rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode_new = mode_t'(wdata);
  assign wr_mode  = wr_en && (addr == ADR_MODE);
  assign rd_rx    = rd_en && (addr == ADR_RXDATA);
  assign rd_err   = rd_en && (addr == ADR_ERR);
  assign tick_g   = bit_tick && mode_q.clk_en;
  assign tx_run   = mode_q.clk_en && mode_q.tx_en && (guard_q == '0);
  assign rx_run   = mode_q.clk_en && mode_q.rx_en && (guard_q == '0);
  assign tx_load  = wr_en && (addr == ADR_TXDATA) && tx_run;
  assign ovr      = rfull_q && !rd_rx;
  assign any_err  = rx_perr || rx_ferr || ovr;

  always_comb begin
    mode_d  = mode_q;
    guard_d = guard_q;
    rdr_d   = rdr_q;
    rfull_d = rfull_q;
    err_d   = err_q;
    if (wr_mode) mode_d = mode_new;
    if (wr_mode && ((mode_q.tx_en && !mode_new.tx_en) || (mode_q.rx_en && !mode_new.rx_en)))
      guard_d = GUARD_W'(GUARD_TICKS);
    else if (tick_g && (guard_q != '0))
      guard_d = guard_q - 1'b1;
    if (rd_rx)  rfull_d = 1'b0;
    if (rd_err) err_d   = '0;
    if (rx_done) begin
      rdr_d   = rx_data;
      rfull_d = 1'b1;
      err_d   = err_d | {rx_perr, rx_ferr, ovr};
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q  <= '0;
      guard_q <= '0;
      rdr_q   <= '0;
      rfull_q <= 1'b0;
      err_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      guard_q <= guard_d;
      rdr_q   <= rdr_d;
      rfull_q <= rfull_d;
      err_q   <= err_d;
    end
  end

  sxcvr_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (tx_run),
    .tick       (tick_g),
    .fmt_len8   (mode_q.len8),
    .fmt_stop2  (mode_q.stop2),
    .fmt_par    (mode_q.par),
    .load       (tx_load),
    .load_data  (wdata),
    .txd        (txd),
    .buf_full   (tx_full),
    .shift_busy (tx_busy),
    .done       (tx_done)
  );

  sxcvr_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (rx_run),
    .tick     (tick_g),
    .fmt_len8 (mode_q.len8),
    .fmt_par  (mode_q.par),
    .rxd      (rxd),
    .done     (rx_done),
    .data     (rx_data),
    .perr     (rx_perr),
    .ferr     (rx_ferr)
  );

  always_comb begin
    case (addr)
      ADR_MODE:   rdata = mode_q;
      ADR_RXDATA: rdata = rdr_q;
      ADR_ERR:    rdata = {5'b0, err_q};
      ADR_TXSTAT: rdata = {6'b0, tx_full, tx_busy};
      default:    rdata = 8'h00;
    endcase
  end

  assign tx_irq    = tx_done;
  assign rx_irq    = rx_done && (!any_err || mode_q.err_on_rx);
  assign rxerr_irq = rx_done && any_err && !mode_q.err_on_rx;

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(rx_irq && rxerr_irq)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_err |=> ((err_q & $past(err_q)) == $past(err_q))); // R8
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_done && rfull_q && !rd_rx) |=> err_q[0]); // R9
  AST_RXDATA_CONSUMED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_rx && !rx_done) |=> !rfull_q); // R7

endmodule

// File: tb/tb_async_serial_xcvr.sv
`timescale 1ns/1ps
module tb_async_serial_xcvr;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       txd;
  logic       rxd = 1'b1;
  logic       tx_irq, rx_irq, rxerr_irq;
  logic [1:0] div_q = 2'd0;
  int         checks = 0, failures = 0;
  int         tx_cnt = 0, rx_cnt = 0, er_cnt = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) div_q <= div_q + 2'd1;
  assign bit_tick = (div_q == 2'd3);  // 16 ticks per bit -> 64 clocks per bit

  always @(negedge clk) begin
    if (tx_irq)    tx_cnt++;
    if (rx_irq)    rx_cnt++;
    if (rxerr_irq) er_cnt++;
  end

  async_serial_xcvr dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .rxerr_irq(rxerr_irq)
  );

  // {mode, data, parity bit expected for that data and mode}
  localparam logic [16:0] VEC [0:5] = '{
    {8'hE5, 8'hA5, 1'b0},   // 8 bits, no parity, 1 stop
    {8'hF5, 8'h3C, 1'b1},   // 8 bits, odd, 1 stop
    {8'hFF, 8'h07, 1'b1},   // 8 bits, even, 2 stop
    {8'hE9, 8'h5A, 1'b0},   // 7 bits, forced zero, 1 stop
    {8'hF3, 8'hC3, 1'b0},   // 7 bits, odd, 2 stop (sends 0x43)
    {8'hFD, 8'hFF, 1'b0}    // 8 bits, even, 1 stop
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic build(input logic [7:0] mode, input logic [7:0] data, input logic par,
                       input bit bad_par, input bit bad_stop,
                       output logic [11:0] bits, output int n);
    bits = '1;
    n = 0;
    bits[n] = 1'b0; n++;
    for (int i = 0; i < (mode[2] ? 8 : 7); i++) begin bits[n] = data[i]; n++; end
    if (mode[4:3] != 2'b00) begin bits[n] = par ^ bad_par; n++; end
    bits[n] = !bad_stop; n++;
    if (mode[1]) begin bits[n] = 1'b1; n++; end
  endtask

  task automatic capture(input int n, output logic [11:0] got);
    int waited = 0;
    got = '1;
    while (txd !== 1'b0 && waited < 3000) begin @(negedge clk); waited++; end
    repeat (32) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (64) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic drive(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = bits[i];
      repeat (63) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (64) @(negedge clk);
  endtask

  task automatic no_start(input int cycles, output bit low_seen);
    low_seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) low_seen = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rv, mode, data;
    logic [11:0] exp_bits, got_bits;
    int          n, c0, c1, c2;
    bit          low;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Reset state: R1
    reg_rd(3'd0, rv); check(rv == 8'h00, "R1 mode after reset", rv, 0);
    reg_rd(3'd4, rv); check(rv == 8'h00, "R6 txstat after reset", rv, 0);
    reg_rd(3'd2, rv); check(rv == 8'h00, "R8 err after reset", rv, 0);
    check(txd === 1'b1, "R1 txd idle after reset", txd, 1);

    // Table walk: R2 R3 R4 R5 on transmit, R7 on receive
    for (int v = 0; v < 6; v++) begin
      mode = VEC[v][16:9];
      data = VEC[v][8:1];
      reg_wr(3'd0, mode);
      reg_rd(3'd0, rv); check(rv == mode, "R1 mode readback", rv, mode);
      build(mode, data, VEC[v][0], 1'b0, 1'b0, exp_bits, n);
      c0 = tx_cnt;
      reg_wr(3'd3, data);
      capture(n, got_bits);
      check(got_bits == exp_bits, "R2/R3/R4/R5 tx frame", got_bits, exp_bits);
      repeat (80) @(negedge clk);
      check(tx_cnt == c0 + 1, "R6 tx_irq once", tx_cnt - c0, 1);
      c1 = rx_cnt;
      drive(exp_bits, n);
      check(rx_cnt == c1 + 1, "R7 rx_irq once", rx_cnt - c1, 1);
      reg_rd(3'd1, rv);
      check(rv == (mode[2] ? data : {1'b0, data[6:0]}), "R2/R7 rx data", rv,
            mode[2] ? data : {1'b0, data[6:0]});
      reg_rd(3'd2, rv); check(rv == 8'h00, "R8 clean frame no error", rv, 0);
    end

    // Transmit status flags: R6
    reg_wr(3'd0, 8'hE5);
    c0 = tx_cnt;
    reg_wr(3'd3, 8'h41);
    reg_wr(3'd3, 8'h42);
    reg_rd(3'd4, rv); check(rv == 8'h03, "R6 waiting and sending", rv, 3);
    for (int i = 0; i < 3000; i++) begin
      reg_rd(3'd4, rv);
      if (rv == 8'h00) break;
    end
    check(rv == 8'h00, "R6 status drains", rv, 0);
    repeat (4) @(negedge clk);
    check(tx_cnt == c0 + 2, "R6 tx_irq per byte", tx_cnt - c0, 2);

    // Parity error routed onto rx_irq: R8 R10
    reg_wr(3'd0, 8'hFD);
    build(8'hFD, 8'h0F, 1'b0, 1'b1, 1'b0, exp_bits, n);
    c1 = rx_cnt; c2 = er_cnt;
    drive(exp_bits, n);
    check(rx_cnt == c1 + 1 && er_cnt == c2, "R10 error on rx_irq", rx_cnt - c1, 1);
    reg_rd(3'd2, rv); check(rv == 8'h04, "R8 parity error bit", rv, 4);
    reg_rd(3'd2, rv); check(rv == 8'h00, "R8 cleared by read", rv, 0);
    reg_rd(3'd1, rv);

    // Framing error routed onto rxerr_irq: R8 R10
    reg_wr(3'd0, 8'hFC);
    build(8'hFC, 8'h0F, 1'b0, 1'b0, 1'b1, exp_bits, n);
    c1 = rx_cnt; c2 = er_cnt;
    drive(exp_bits, n);
    check(er_cnt == c2 + 1, "R10 rxerr_irq pulse", er_cnt - c2, 1);
    check(rx_cnt == c1, "R10 rx_irq silent", rx_cnt - c1, 0);
    reg_rd(3'd2, rv); check(rv == 8'h02, "R8 framing error bit", rv, 2);
    reg_rd(3'd1, rv);

    // Overrun: R9
    reg_wr(3'd0, 8'hE5);
    build(8'hE5, 8'h11, 1'b0, 1'b0, 1'b0, exp_bits, n);
    drive(exp_bits, n);
    build(8'hE5, 8'h22, 1'b0, 1'b0, 1'b0, exp_bits, n);
    drive(exp_bits, n);
    reg_rd(3'd2, rv); check(rv == 8'h01, "R9 overrun bit", rv, 1);
    reg_rd(3'd1, rv); check(rv == 8'h22, "R9 newest data kept", rv, 8'h22);

    // Guard after clearing enables: R11
    reg_wr(3'd0, 8'h85);
    reg_wr(3'd0, 8'hE5);
    reg_wr(3'd3, 8'h11);
    reg_rd(3'd4, rv); check(rv == 8'h00, "R11 write ignored in guard", rv, 0);
    no_start(200, low);
    check(!low, "R11 txd quiet in guard", low, 0);
    reg_wr(3'd3, 8'h22);
    reg_rd(3'd4, rv); check(rv[0] == 1'b1, "R11 runs after guard", rv, 1);
    repeat (800) @(negedge clk);

    // Fully disabled channel: R1
    reg_wr(3'd0, 8'h00);
    reg_wr(3'd3, 8'h33);
    reg_rd(3'd4, rv); check(rv == 8'h00, "R1 disabled tx write ignored", rv, 0);
    c1 = rx_cnt; c2 = er_cnt;
    build(8'hE5, 8'h5C, 1'b0, 1'b0, 1'b0, exp_bits, n);
    drive(exp_bits, n);
    check(rx_cnt == c1 && er_cnt == c2, "R1 disabled no receive", rx_cnt - c1, 0);
    check(txd === 1'b1, "R1 disabled txd high", txd, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule